// File: doc/BRIEF.md
# Four-Column Multi-Read-Address Memory

This block is a 64-word by 4-bit storage array split into four 1-bit columns. One shared address, the read/write address, selects the word that is written: on the active write-clock edge, while the write enable is high, each of the four data bits goes into its own column at that address. Each column drives its own 1-bit output. Column 3 is read at the read/write address. Columns 0, 1 and 2 are read at three independent read-only addresses. All reads are combinational.

Tying the addresses or data inputs together gives different memory shapes from the same array. With all four read addresses tied to the read/write address, it is a 64x4 single-port RAM. With the three read-only addresses tied together, it is a 64x3 simple dual-port RAM. With the four data inputs tied together, it is a 64x1 RAM with one read/write port and three extra read ports. A parameter per column gives the power-up contents. A further parameter moves writes from the rising to the falling edge of the write clock. The array has no reset.

Top module: `quadcol_ram`

## Requirements
- R1: The array has 64 words addressed by 6-bit addresses. On the active write-clock edge with `wr_en` high, `wr_data[i]` is stored in column i at `rw_addr`, for i = 0..3.
- R2: `q0`, `q1` and `q2` show column 0, 1 and 2 at `rd_addr0`, `rd_addr1` and `rd_addr2`. `q3` shows column 3 at `rw_addr`.
- R3: Reads are combinational. An output follows a change of its address without any clock edge.
- R4: With `wr_en` low at the active edge, no column changes, whatever `rw_addr` and `wr_data` carry.
- R5: Bit z of `INIT_COL<i>` is the content of column i at address z before any write. Every `INIT_COL<i>` defaults to all zeros.
- R6: With `WR_ON_FALL` = 1, writes happen on the falling edge of `wr_clk` and the rising edge stores nothing. With `WR_ON_FALL` = 0 (the default), writes happen only on the rising edge.
- R7: A read at the address being written shows the old value up to the active edge and the new value at once after it, with no bypass path.
- R8: With all four addresses equal, the block acts as a 64x4 single-port RAM: `{q3,q2,q1,q0}` equals the last nibble written at that address.
- R9: With the same bit on all four `wr_data` lines, the block acts as a 64x1 RAM, and all four outputs return that bit for an address on any port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock; the active edge is set by `WR_ON_FALL` |
| wr_en | input | 1 | Write enable, sampled on the active edge |
| rw_addr | input | 6 | Write address for all columns and read address for column 3 |
| rd_addr0 | input | 6 | Read address of column 0 |
| rd_addr1 | input | 6 | Read address of column 1 |
| rd_addr2 | input | 6 | Read address of column 2 |
| wr_data | input | 4 | Write data; bit i goes to column i |
| q0 | output | 1 | Column 0 at `rd_addr0` |
| q1 | output | 1 | Column 1 at `rd_addr1` |
| q2 | output | 1 | Column 2 at `rd_addr2` |
| q3 | output | 1 | Column 3 at `rw_addr` |

## Verification
A read is due in the same cycle as its address, with no register in the path. The bench changes an address and samples one time unit later, and it steps several addresses inside a single clock phase to show that no edge is involved.

A write is visible just after the one active edge that stores it. The bench raises the enable a quarter period after a rising edge. It samples one time unit after the following falling edge, where the falling-edge instance has the new value and the rising-edge instance still has the old one. It samples again one time unit after the next rising edge, where both instances have the new value. Two instances run the same stimulus, one for each edge setting, and each is checked against its own reference array.

// File: rtl/quadcol_ram.sv
module quadcol_ram #(
  parameter int ADDR_W = 6,
  parameter logic [(1<<ADDR_W)-1:0] INIT_COL0 = '0,
  parameter logic [(1<<ADDR_W)-1:0] INIT_COL1 = '0,
  parameter logic [(1<<ADDR_W)-1:0] INIT_COL2 = '0,
  parameter logic [(1<<ADDR_W)-1:0] INIT_COL3 = '0,
  parameter bit WR_ON_FALL = 1'b0
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] rw_addr,
  input  logic [ADDR_W-1:0] rd_addr0,
  input  logic [ADDR_W-1:0] rd_addr1,
  input  logic [ADDR_W-1:0] rd_addr2,
  input  logic [3:0]        wr_data,
  output logic              q0,
  output logic              q1,
  output logic              q2,
  output logic              q3
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NCOL  = 4;

  logic [DEPTH-1:0] col [NCOL];

  initial begin
    col[0] = INIT_COL0;
    col[1] = INIT_COL1;
    col[2] = INIT_COL2;
    col[3] = INIT_COL3;
  end

  generate
    if (WR_ON_FALL) begin : g_fall
      always_ff @(negedge wr_clk)
        if (wr_en)
          for (int i = 0; i < NCOL; i++) col[i][rw_addr] <= wr_data[i];
    end else begin : g_rise
      always_ff @(posedge wr_clk)
        if (wr_en)
          for (int i = 0; i < NCOL; i++) col[i][rw_addr] <= wr_data[i];
    end
  endgenerate

  assign q0 = col[0][rd_addr0];
  assign q1 = col[1][rd_addr1];
  assign q2 = col[2][rd_addr2];
  assign q3 = col[3][rw_addr];
endmodule

// File: rtl/quadcol_ram_chk.sv
module quadcol_ram_chk #(
  parameter int ADDR_W = 6,
  parameter logic [(1<<ADDR_W)-1:0] INIT_COL0 = '0,
  parameter logic [(1<<ADDR_W)-1:0] INIT_COL1 = '0,
  parameter logic [(1<<ADDR_W)-1:0] INIT_COL2 = '0,
  parameter logic [(1<<ADDR_W)-1:0] INIT_COL3 = '0,
  parameter bit WR_ON_FALL = 1'b0
) (
  input logic              wr_clk,
  input logic              wr_en,
  input logic [ADDR_W-1:0] rw_addr,
  input logic [ADDR_W-1:0] rd_addr0,
  input logic [ADDR_W-1:0] rd_addr1,
  input logic [ADDR_W-1:0] rd_addr2,
  input logic [3:0]        wr_data,
  input logic              q0,
  input logic              q1,
  input logic              q2,
  input logic              q3
);
  logic act_clk;
  logic primed;
  assign act_clk = WR_ON_FALL ? ~wr_clk : wr_clk;

  initial primed = 1'b0;
  always @(posedge act_clk) primed <= 1'b1;

  // R5: power-up contents seen at the first active edge
  always @(posedge act_clk) begin
    if (!primed) begin
      a_r5_init_col0: assert (q0 == INIT_COL0[rd_addr0]);
      a_r5_init_col3: assert (q3 == INIT_COL3[rw_addr]);
    end
  end

  a_r1_write_col3: assert property (@(posedge act_clk) disable iff (!primed)
    wr_en |=> ($stable(rw_addr) -> (q3 == $past(wr_data[3]))));

  a_r2_write_col0: assert property (@(posedge act_clk) disable iff (!primed)
    (wr_en && rd_addr0 == rw_addr) |=>
      (($stable(rw_addr) && $stable(rd_addr0)) -> (q0 == $past(wr_data[0]))));

  a_r4_hold_col0: assert property (@(posedge act_clk) disable iff (!primed)
    !wr_en |=> ($stable(rd_addr0) -> $stable(q0)));

  a_r4_hold_col3: assert property (@(posedge act_clk) disable iff (!primed)
    !wr_en |=> ($stable(rw_addr) -> $stable(q3)));
endmodule

bind quadcol_ram quadcol_ram_chk #(
  .ADDR_W(ADDR_W), .INIT_COL0(INIT_COL0), .INIT_COL1(INIT_COL1),
  .INIT_COL2(INIT_COL2), .INIT_COL3(INIT_COL3), .WR_ON_FALL(WR_ON_FALL)
) chk_i (.*);

// File: tb/quadcol_ram_tb_top.sv
module quadcol_ram_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] I0 = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] I1 = 64'hF0F0_0F0F_AAAA_5555;
  localparam logic [63:0] I2 = 64'h8000_0000_0000_0001;
  localparam logic [63:0] I3 = 64'hDEAD_BEEF_C0DE_1234;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       wr_en = 1'b0;
  logic [5:0] rw_addr = '0, ra0 = '0, ra1 = '0, ra2 = '0;
  logic [3:0] wdata = '0;
  logic qr0, qr1, qr2, qr3, qf0, qf1, qf2, qf3;

  quadcol_ram #(.INIT_COL0(I0), .INIT_COL1(I1), .INIT_COL2(I2), .INIT_COL3(I3)) dut_i (
    .wr_clk(clk), .wr_en(wr_en), .rw_addr(rw_addr), .rd_addr0(ra0), .rd_addr1(ra1),
    .rd_addr2(ra2), .wr_data(wdata), .q0(qr0), .q1(qr1), .q2(qr2), .q3(qr3));

  quadcol_ram #(.WR_ON_FALL(1'b1)) dut_fall_i (
    .wr_clk(clk), .wr_en(wr_en), .rw_addr(rw_addr), .rd_addr0(ra0), .rd_addr1(ra1),
    .rd_addr2(ra2), .wr_data(wdata), .q0(qf0), .q1(qf1), .q2(qf2), .q3(qf3));

  logic [63:0] mr [4];
  logic [63:0] mf [4];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic check(string req, logic [3:0] act, logic [3:0] exp, string who);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", req, who, act, exp);
    end
  endtask

  task automatic compare(string req);
    check(req, {qr3, qr2, qr1, qr0},
          {mr[3][rw_addr], mr[2][ra2], mr[1][ra1], mr[0][ra0]}, "rise");
    check(req, {qf3, qf2, qf1, qf0},
          {mf[3][rw_addr], mf[2][ra2], mf[1][ra1], mf[0][ra0]}, "fall");
  endtask

  // R6 R7: falling instance updates at the falling edge, rising one only later
  task automatic do_write(logic [5:0] a, logic [3:0] d, logic en, string req);
    @(posedge clk); #(CLK_PERIOD/4);
    rw_addr = a; wdata = d; wr_en = en;
    #1 compare({req, " R7 pre-edge"});
    @(negedge clk); #1;
    if (en) for (int i = 0; i < 4; i++) mf[i][a] = d[i];
    compare({req, " R6 after falling edge"});
    @(posedge clk); #1;
    if (en) for (int i = 0; i < 4; i++) mr[i][a] = d[i];
    compare({req, " R7 after rising edge"});
    wr_en = 1'b0;
  endtask

  task automatic t_init();
    for (int a = 0; a < 64; a++) begin
      rw_addr = 6'(a); ra0 = 6'(63 - a); ra1 = 6'(a); ra2 = 6'(a ^ 21);
      #1 compare("R5 init");
    end
  endtask

  task automatic t_comb();
    @(posedge clk); #1;
    ra0 = 6'd0; ra1 = 6'd1; ra2 = 6'd2; rw_addr = 6'd3; #1 compare("R3 comb");
    ra0 = 6'd7; ra1 = 6'd40; ra2 = 6'd63; rw_addr = 6'd12; #1 compare("R3 comb");
    ra0 = 6'd63; ra1 = 6'd0; ra2 = 6'd31; rw_addr = 6'd62; #1 compare("R3 comb");
  endtask

  task automatic t_basic();
    do_write(6'd5, 4'b1010, 1'b1, "R1");
    do_write(6'd63, 4'b0111, 1'b1, "R1");
    do_write(6'd0, 4'b1100, 1'b1, "R1");
    ra0 = 6'd5; ra1 = 6'd63; ra2 = 6'd0; rw_addr = 6'd5; #1 compare("R2 ports");
    ra0 = 6'd0; ra1 = 6'd5; ra2 = 6'd63; rw_addr = 6'd0; #1 compare("R2 ports");
  endtask

  task automatic t_noen();
    ra0 = 6'd9; ra1 = 6'd9; ra2 = 6'd9;
    do_write(6'd9, ~{mr[3][9], mr[2][9], mr[1][9], mr[0][9]}, 1'b0, "R4 disabled");
    do_write(6'd5, 4'b0101, 1'b0, "R4 disabled");
    rw_addr = 6'd5; ra0 = 6'd5; ra1 = 6'd5; ra2 = 6'd5; #1 compare("R4 hold");
  endtask

  task automatic t_single();
    for (int k = 0; k < 4; k++) begin
      logic [5:0] a = 6'(17 + 9 * k);
      logic [3:0] d = 4'(3 * k + 6);
      ra0 = a; ra1 = a; ra2 = a;
      do_write(a, d, 1'b1, "R8");
      check("R8 single-port", {qr3, qr2, qr1, qr0}, d, "rise");
      check("R8 single-port", {qf3, qf2, qf1, qf0}, d, "fall");
    end
  endtask

  task automatic t_quad();
    do_write(6'd30, 4'b1111, 1'b1, "R9");
    do_write(6'd31, 4'b0000, 1'b1, "R9");
    rw_addr = 6'd30; ra0 = 6'd31; ra1 = 6'd30; ra2 = 6'd31; #1;
    check("R9 quad-port", {qr3, qr2, qr1, qr0}, 4'b1010, "rise");
    check("R9 quad-port", {qf3, qf2, qf1, qf0}, 4'b1010, "fall");
    rw_addr = 6'd31; ra0 = 6'd30; ra1 = 6'd31; ra2 = 6'd30; #1;
    check("R9 quad-port", {qr3, qr2, qr1, qr0}, 4'b0101, "rise");
    check("R9 quad-port", {qf3, qf2, qf1, qf0}, 4'b0101, "fall");
  endtask

  task automatic t_random();
    for (int n = 0; n < 400; n++) begin
      ra0 = 6'($urandom); ra1 = 6'($urandom); ra2 = 6'($urandom);
      do_write(6'($urandom), 4'($urandom), 1'($urandom % 4 != 0), "R1 R2 random");
      ra0 = 6'($urandom); ra1 = 6'($urandom); ra2 = 6'($urandom);
      #1 compare("R2 random read");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    mr[0] = I0; mr[1] = I1; mr[2] = I2; mr[3] = I3;
    for (int i = 0; i < 4; i++) mf[i] = '0;
    void'($urandom(32'd7));
    t_init();
    t_comb();
    t_basic();
    t_noen();
    t_single();
    t_quad();
    t_random();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule